// File: doc/BRIEF.md
# Power domain gating sequencer

This block switches a single power domain off and back on under software control. Software reaches it over a simple 32-bit register bus. Writing a request bit into the control register starts a sequence. When the domain goes down, the block first raises the isolation enable, waits a programmed number of clock cycles and then opens the power switch. When the domain comes back, it closes the switch first, waits and then releases isolation. A domain-off status output reports when the domain is fully down. Each request bit clears itself in hardware when its sequence has finished.

Each direction has its own timing register with two 6-bit phase fields, and the total wait is the sum of the two fields. A bank of four 32-bit mask words covers 128 interrupt lines. While the domain is off, any active line that is not masked raises a wake request.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset the switch enable is 1, the isolation enable is 0 and the domain-off status is 0. The control, gating-enable and both timing registers read 0, and all four mask words read 0xFFFFFFFF.
- R2: The register map is as follows. Control is at 0x000. The mask words are at 0x008, 0x00C, 0x010 and 0x014, covering lines 0-31, 32-63, 64-95 and 96-127. Gating enable is bit 0 at 0x260. Power-up timing is at 0x264, with the switch delay in [5:0] and the switch-to-isolation delay in [13:8]. Power-down timing is at 0x268, with the isolation delay in [5:0] and the isolation-to-switch delay in [13:8]. `bus_ready` pulses exactly one cycle after an access, and read data is valid with it. Unmapped addresses read 0 and ignore writes.
- R3: Writing 1 to control bit 0, with gating enabled and the domain on, starts a power-down. Isolation rises on the second clock edge after the write edge. The switch opens and the domain-off status sets S+1 cycles after isolation rises, where S is the sum of the two power-down timing fields.
- R4: Writing 1 to control bit 1 while the domain is off starts a power-up. The switch closes on the second clock edge after the write edge. Isolation is released and the domain-off status clears S+1 cycles later, where S is the sum of the two power-up timing fields.
- R5: A power-down request while gating-enable bit 0 is 0 changes no output, and the request bit clears.
- R6: A request bit reads 1 while its request is pending or running. It reads 0 once the sequence has completed.
- R7: A request written while a sequence is running is held pending. It is carried out after the running sequence completes.
- R8: A control write with both bits 0 and 1 set records only the power-up request.
- R9: While the domain is off, `wake_req` is 1 whenever any interrupt line is 1 and its mask bit is 0. A mask bit of 1 blocks its line.
- R10: While the domain-off status is 0, `wake_req` stays 0 whatever the lines and masks are.
- R11: A request for the state the domain is already in changes no output, and the request bit clears.
- R12: The switch is never open while isolation is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sequencing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completion pulse |
| irq_lines | input | 128 | Interrupt lines, active high |
| iso_en | output | 1 | Isolation enable |
| sw_en | output | 1 | Power switch enable (1 = powered) |
| dom_off | output | 1 | Domain fully off |
| wake_req | output | 1 | Wake request to the power sequencer's owner |

## Verification
The assertions check on every cycle that the switch is never open without isolation and that the off status always agrees with the switch. They also check that isolation rises only when a pending power-down is launched and falls only at the end of a power-up. The one-cycle bus response, the power-up priority on a double write and the blocking of gating by a cleared enable bit are also checked by assertions. Only the bench scenarios can show the exact phase lengths derived from the timing fields, the holding of a request made in mid-sequence, and the self-clearing of request bits seen through register reads. They also cover the mask-driven wake behaviour line by line.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int FLD_W  = 6;
  localparam int SUM_W  = FLD_W + 1;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_MASK = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_GATE = 12'h260;
  localparam logic [ADDR_W-1:0] OFS_PUPT = 12'h264;
  localparam logic [ADDR_W-1:0] OFS_PDNT = 12'h268;

  typedef struct packed {
    logic [FLD_W-1:0] second;
    logic [FLD_W-1:0] first;
  } phase_time_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DOWN = 2'd1,
    ST_UP   = 2'd2
  } seq_state_t;

  function automatic logic [SUM_W-1:0] phase_sum(phase_time_t t);
    return {1'b0, t.first} + {1'b0, t.second};
  endfunction

  function automatic logic [ADDR_W-1:0] mask_addr(int idx);
    return OFS_MASK + ADDR_W'(4 * idx);
  endfunction

  function automatic logic [DATA_W-1:0] time_word(phase_time_t t);
    logic [DATA_W-1:0] w;
    w = '0;
    w[FLD_W-1:0]   = t.first;
    w[8+FLD_W-1:8] = t.second;
    return w;
  endfunction

endpackage

// File: rtl/pgs_regs.sv
module pgs_regs
  import pgs_pkg::*;
#(
  parameter int N_MASK = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_en,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_ready,
  input  logic                     clr_down,
  input  logic                     clr_up,
  output logic                     req_down,
  output logic                     req_up,
  output logic                     gate_on,
  output phase_time_t              up_time,
  output phase_time_t              down_time,
  output logic [N_MASK*DATA_W-1:0] mask_flat
);

  logic wr;
  logic wr_ctrl;
  logic set_down;
  logic set_up;
  logic [DATA_W-1:0] rd_mux;

  assign wr       = bus_en && bus_we;
  assign wr_ctrl  = wr && (bus_addr == OFS_CTRL);
  assign set_up   = wr_ctrl && bus_wdata[1];
  assign set_down = wr_ctrl && bus_wdata[0] && !bus_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_down <= 1'b0;
      req_up   <= 1'b0;
    end else begin
      req_down <= set_down || (req_down && !clr_down);
      req_up   <= set_up   || (req_up   && !clr_up);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_on   <= 1'b0;
      up_time   <= '0;
      down_time <= '0;
    end else if (wr) begin
      if (bus_addr == OFS_GATE) gate_on <= bus_wdata[0];
      if (bus_addr == OFS_PUPT) up_time <= '{second: bus_wdata[13:8], first: bus_wdata[5:0]};
      if (bus_addr == OFS_PDNT) down_time <= '{second: bus_wdata[13:8], first: bus_wdata[5:0]};
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_MASK; g++) begin : g_mask
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '1;
        else if (wr && bus_addr == mask_addr(g)) word_q <= bus_wdata;
      end
      assign mask_flat[g*DATA_W +: DATA_W] = word_q;
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFS_CTRL) rd_mux = {30'b0, req_up, req_down};
    if (bus_addr == OFS_GATE) rd_mux = {31'b0, gate_on};
    if (bus_addr == OFS_PUPT) rd_mux = time_word(up_time);
    if (bus_addr == OFS_PDNT) rd_mux = time_word(down_time);
    for (int i = 0; i < N_MASK; i++) begin
      if (bus_addr == mask_addr(i)) rd_mux = mask_flat[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_en;
      bus_rdata <= (bus_en && !bus_we) ? rd_mux : '0;
    end
  end

  // R2: every access is answered on the next cycle, and only then
  p_ready_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |=> bus_ready);
  p_ready_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> $past(bus_en));
  // R8: a double request never records a new power-down
  p_up_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[1] && bus_wdata[0]) |=> (req_up && (!req_down || $past(req_down))));

endmodule

// File: rtl/pgs_seq.sv
module pgs_seq
  import pgs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_down,
  input  logic        req_up,
  input  logic        gate_on,
  input  phase_time_t up_time,
  input  phase_time_t down_time,
  output logic        clr_down,
  output logic        clr_up,
  output logic        iso_en,
  output logic        sw_en,
  output logic        dom_off
);

  seq_state_t       state;
  logic [SUM_W-1:0] cnt;

  // named internal events
  logic start_down;
  logic start_up;
  logic skip_down;
  logic skip_up;
  logic cnt_zero;
  logic done_down;
  logic done_up;

  assign cnt_zero   = (cnt == '0);
  assign skip_up    = (state == ST_IDLE) && req_up && !dom_off;
  assign start_up   = (state == ST_IDLE) && req_up && dom_off;
  assign skip_down  = (state == ST_IDLE) && !req_up && req_down && (dom_off || !gate_on);
  assign start_down = (state == ST_IDLE) && !req_up && req_down && !dom_off && gate_on;
  assign done_down  = (state == ST_DOWN) && cnt_zero;
  assign done_up    = (state == ST_UP) && cnt_zero;

  assign clr_down = skip_down || done_down;
  assign clr_up   = skip_up || done_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      iso_en  <= 1'b0;
      sw_en   <= 1'b1;
      dom_off <= 1'b0;
    end else begin
      if (start_up) begin
        sw_en <= 1'b1;
        cnt   <= phase_sum(up_time);
        state <= ST_UP;
      end else if (start_down) begin
        iso_en <= 1'b1;
        cnt    <= phase_sum(down_time);
        state  <= ST_DOWN;
      end else if (done_down) begin
        sw_en   <= 1'b0;
        dom_off <= 1'b1;
        state   <= ST_IDLE;
      end else if (done_up) begin
        iso_en  <= 1'b0;
        dom_off <= 1'b0;
        state   <= ST_IDLE;
      end else if (state != ST_IDLE) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R12: an open switch always sits behind isolation and is reported as off
  p_iso_guard_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |-> (iso_en && dom_off));
  p_off_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dom_off |-> iso_en);
  // R3: isolation rises only when a pending power-down is launched
  p_iso_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iso_en) |-> ($past(req_down) && $past(state == ST_IDLE) && sw_en));
  // R4: isolation falls only at the end of a power-up with the switch closed
  p_iso_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> ($past(state == ST_UP) && sw_en && !dom_off));
  // R5: a power-down request with gating disabled leaves isolation untouched
  p_gate_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && req_down && !req_up && !gate_on) |=> ($stable(iso_en) && $stable(sw_en)));

endmodule

// File: rtl/pgs_wake.sv
module pgs_wake
  import pgs_pkg::*;
#(
  parameter int N_MASK = 4
) (
  input  logic [N_MASK*DATA_W-1:0] irq_lines,
  input  logic [N_MASK*DATA_W-1:0] mask_flat,
  input  logic                     dom_off,
  output logic                     wake_req
);

  logic [N_MASK-1:0] word_hit;

  genvar g;
  generate
    for (g = 0; g < N_MASK; g++) begin : g_hit
      assign word_hit[g] = |(irq_lines[g*DATA_W +: DATA_W] & ~mask_flat[g*DATA_W +: DATA_W]);
    end
  endgenerate

  assign wake_req = dom_off && (|word_hit);

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
  import pgs_pkg::*;
#(
  parameter int N_MASK = 4,
  localparam int IRQ_W = N_MASK * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  input  logic [IRQ_W-1:0]  irq_lines,
  output logic              iso_en,
  output logic              sw_en,
  output logic              dom_off,
  output logic              wake_req
);

  logic        req_down;
  logic        req_up;
  logic        clr_down;
  logic        clr_up;
  logic        gate_on;
  phase_time_t up_time;
  phase_time_t down_time;
  logic [IRQ_W-1:0] mask_flat;

  pgs_regs #(.N_MASK(N_MASK)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .clr_down  (clr_down),
    .clr_up    (clr_up),
    .req_down  (req_down),
    .req_up    (req_up),
    .gate_on   (gate_on),
    .up_time   (up_time),
    .down_time (down_time),
    .mask_flat (mask_flat)
  );

  pgs_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_down  (req_down),
    .req_up    (req_up),
    .gate_on   (gate_on),
    .up_time   (up_time),
    .down_time (down_time),
    .clr_down  (clr_down),
    .clr_up    (clr_up),
    .iso_en    (iso_en),
    .sw_en     (sw_en),
    .dom_off   (dom_off)
  );

  pgs_wake #(.N_MASK(N_MASK)) u_wake (
    .irq_lines (irq_lines),
    .mask_flat (mask_flat),
    .dom_off   (dom_off),
    .wake_req  (wake_req)
  );

  // R10: no wake request while the domain is powered
  p_wake_off_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dom_off && !$past(dom_off)) |-> !wake_req);

endmodule

// File: tb/sim_pwr_gate_seq.sv
`timescale 1ns/1ps
module sim_pwr_gate_seq;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_en = 1'b0;
  logic         bus_we = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_ready;
  logic [127:0] irq_lines = '0;
  logic         iso_en, sw_en, dom_off, wake_req;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pwr_gate_seq u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .irq_lines(irq_lines), .iso_en(iso_en),
    .sw_en(sw_en), .dom_off(dom_off), .wake_req(wake_req)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0;
    chk("R2 ready", 32'(bus_ready), 32'd1);
    d = bus_rdata;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // counts negedges after the request write until the chosen output takes value v
  task automatic wait_for(int which, logic v, output int n);
    logic cur;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      cur = (which == 0) ? sw_en : (which == 1) ? iso_en : dom_off;
    end while (cur !== v && n < 300);
  endtask

  task automatic t_reset();
    chk("R1 sw", 32'(sw_en), 1);
    chk("R1 iso", 32'(iso_en), 0);
    chk("R1 off", 32'(dom_off), 0);
    rd_chk("R1 ctrl", 12'h000, 0);
    rd_chk("R1 gate", 12'h260, 0);
    rd_chk("R1 pup time", 12'h264, 0);
    rd_chk("R1 pdn time", 12'h268, 0);
    for (int i = 0; i < 4; i++) rd_chk("R1 mask", 12'h008 + 12'(4*i), 32'hFFFF_FFFF);
  endtask

  task automatic t_map();
    wr(12'h264, 32'hFFFF_FFFF);
    rd_chk("R2 pup fields", 12'h264, 32'h0000_3F3F);
    wr(12'h00C, 32'h1234_5678);
    rd_chk("R2 mask1", 12'h00C, 32'h1234_5678);
    wr(12'h00C, 32'hFFFF_FFFF);
    wr(12'h100, 32'hDEAD_BEEF);
    rd_chk("R2 unmapped", 12'h100, 0);
    wr(12'h264, 32'h0);
  endtask

  task automatic t_wake_on();
    wr(12'h008, 32'hFFFF_FFFE);
    irq_lines = 128'h1;
    #1;
    chk("R10 wake while on", 32'(wake_req), 0);
    irq_lines = '0;
  endtask

  task automatic t_gate_off();
    wr(12'h000, 32'h1);
    repeat (6) @(negedge clk);
    chk("R5 sw", 32'(sw_en), 1);
    chk("R5 iso", 32'(iso_en), 0);
    rd_chk("R5 req cleared", 12'h000, 0);
  endtask

  task automatic t_down();
    int n;
    wr(12'h260, 32'h1);
    wr(12'h268, 32'h0000_0304);
    rd_chk("R2 pdn fields", 12'h268, 32'h0000_0304);
    wr(12'h000, 32'h1);
    @(negedge clk);
    chk("R3 iso up", 32'(iso_en), 1);
    chk("R3 sw still on", 32'(sw_en), 1);
    wait_for(0, 1'b0, n);
    chk("R3 switch off delay", n + 1, 3 + 4 + 2);
    chk("R3 off status", 32'(dom_off), 1);
    rd_chk("R6 ctrl cleared", 12'h000, 0);
  endtask

  task automatic t_wake_off();
    irq_lines = 128'h1;
    #1;
    chk("R9 unmasked line", 32'(wake_req), 1);
    irq_lines = 128'h2;
    #1;
    chk("R9 masked line", 32'(wake_req), 0);
    irq_lines = 128'h0;
    irq_lines[33] = 1'b1;
    #1;
    chk("R9 masked word1", 32'(wake_req), 0);
    wr(12'h00C, 32'hFFFF_FFFD);
    chk("R9 unmasked word1", 32'(wake_req), 1);
    wr(12'h00C, 32'hFFFF_FFFF);
    irq_lines = '0;
  endtask

  task automatic t_same_state();
    wr(12'h000, 32'h1);
    repeat (4) @(negedge clk);
    rd_chk("R11 ctrl cleared", 12'h000, 0);
    chk("R11 still off", 32'(dom_off), 1);
    chk("R11 switch open", 32'(sw_en), 0);
  endtask

  task automatic t_up_both();
    int n;
    wr(12'h264, 32'h0000_0201);
    wr(12'h000, 32'h3);
    rd_chk("R8 only up recorded", 12'h000, 32'h2);
    wait_for(1, 1'b0, n);
    chk("R4 off cleared", 32'(dom_off), 0);
    chk("R4 switch on", 32'(sw_en), 1);
    repeat (20) @(negedge clk);
    chk("R8 no down run", 32'(sw_en), 1);
    chk("R8 iso stays low", 32'(iso_en), 0);
  endtask

  task automatic t_up_timing();
    int n;
    wr(12'h000, 32'h1);
    wait_for(2, 1'b1, n);
    wr(12'h264, 32'h0000_0502);
    wr(12'h000, 32'h2);
    @(negedge clk);
    chk("R4 switch on first", 32'(sw_en), 1);
    chk("R4 iso held", 32'(iso_en), 1);
    wait_for(1, 1'b0, n);
    chk("R4 release delay", n + 1, 5 + 2 + 2);
    chk("R4 off cleared", 32'(dom_off), 0);
    irq_lines = '1;
    #1;
    chk("R10 wake after up", 32'(wake_req), 0);
    irq_lines = '0;
  endtask

  task automatic t_held();
    int n;
    wr(12'h268, 32'h0000_0707);
    wr(12'h000, 32'h1);
    wr(12'h000, 32'h2);
    rd_chk("R7 both pending", 12'h000, 32'h3);
    wait_for(0, 1'b0, n);
    chk("R7 down finished first", 32'(dom_off), 1);
    wait_for(2, 1'b0, n);
    chk("R7 held up ran", 32'(sw_en), 1);
    chk("R7 iso released", 32'(iso_en), 0);
    rd_chk("R6 R7 ctrl clear", 12'h000, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_wake_on();
    t_gate_off();
    t_down();
    t_wake_off();
    t_same_state();
    t_up_both();
    t_up_timing();
    t_held();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule